// File: doc/BRIEF.md
# I2C Bus Clock and Condition Timing Generator

This block produces the serial clock of an I2C controller and decides, to the input clock, when the data line may change, when it should be sampled, and when START and STOP conditions are placed. The two halves of the clock period come from separate 16-bit low and high counts held in one 32-bit divider word. Each count has an implicit +1, so with l = low count + 1 and h = high count + 1 the low half lasts 8·l input clocks and the high half lasts 8·h. Three small tuning fields place the data update point inside the low half and stretch the START and STOP setup windows in whole multiples of 8·h.

A byte-level sequencer drives the block one operation at a time: a START, a STOP, or a single data bit. The block raises `ready_o` when it can take the next operation. It signals the update and sample instants with one-cycle strobes, and it reports each completed operation with a one-cycle pulse. Divider and tuning values are captured when an operation is accepted, so values written in the middle of a transfer take effect at the next bit boundary. When the enable input is low, both bus lines are released high and every counter is cleared.

Top module: `i2c_clk_gen`

## Requirements
- R1: After reset, and whenever no operation is running on an idle bus, `scl_o` and `sda_o` are both 1 and `ready_o` is 1.
- R2: `div_i[15:0]` is the low count and `div_i[31:16]` the high count. In a bit operation SCL stays low for 8·l clocks from the acceptance edge, then stays high for 8·h clocks.
- R3: The SDA update field gives s = field + 1, limited to 7 for field values of 6 and above. SDA takes the new bit l·s + 1 clocks after the low phase begins, and `upd_stb_o` is high in the cycle that ends with that change, while SCL is low.
- R4: `smp_stb_o` is high for exactly one cycle, 4·h clocks after SCL rises, and only while SCL is high.
- R5: With u = START field + 1, a START accepted on an idle bus pulls SDA low 8·h·u + 1 clocks after acceptance. SCL falls 8·h·(u+1) − 1 clocks after that, and `sta_done_o` is high in the final cycle before the fall. SDA never falls while SCL is held high outside this point.
- R6: A START issued while the bus is held (repeated START) first runs a low phase that releases SDA to 1. After SCL rises, SDA falls 8·h·u + 1 clocks later.
- R7: With p = STOP field + 1, a STOP drives SDA low during its low phase. SDA rises 8·h·p + 1 clocks after SCL rises, and the bus then returns to idle. SDA never rises while SCL is held high other than at the end of a STOP.
- R8: A bit request accepted in the last cycle of the previous high phase starts its low phase on the SCL falling edge, so successive SCL rising edges are exactly 8·(l + h) clocks apart.
- R9: Divider and tuning inputs are sampled only when an operation is accepted. A change during an operation does not alter that operation's timing, and the next accepted operation uses the new value.
- R10: If either count field is zero, `ready_o` stays 0, requests are ignored, and both bus lines stay released.
- R11: Bit and STOP requests on an idle bus are ignored: SCL and SDA remain 1.
- R12: One cycle after `en_i` goes low, `scl_o` and `sda_o` are 1 and any operation is abandoned. `ready_o` is 0 while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low releases the bus and clears counters |
| div_i | input | 32 | High count [31:16], low count [15:0] |
| sda_cfg_i | input | 4 | SDA update point field |
| sta_cfg_i | input | 2 | START setup/hold stretch field |
| sto_cfg_i | input | 2 | STOP setup stretch field |
| req_start_i | input | 1 | Request a START or repeated START (highest priority) |
| req_stop_i | input | 1 | Request a STOP (second priority) |
| req_bit_i | input | 1 | Request one data bit |
| bit_i | input | 1 | Data value for a bit request |
| ready_o | output | 1 | A request presented now is accepted at the next edge |
| scl_o | output | 1 | Serial clock level (1 = released) |
| sda_o | output | 1 | Serial data level (1 = released) |
| upd_stb_o | output | 1 | Cycle ending with the SDA update |
| smp_stb_o | output | 1 | SDA sampling cycle in the high phase |
| sta_done_o | output | 1 | Last cycle of a START |
| sto_done_o | output | 1 | Last cycle of a STOP |
| bit_done_o | output | 1 | Last cycle of a data bit |

## Verification
The assertions assume the sequencer raises a request only when `ready_o` is high, and holds `div_i` nonzero in both fields while an operation runs from a valid load. The phase counter check relies on that load having happened before any phase runs. The bench meets these assumptions by waiting for `ready_o` in its issue task before driving each request. The only deliberate violations are the zero-divider and idle-request cases, and there the design is expected to ignore the request. Configuration changes are made only while an operation is already latched, which is the case the boundary rule covers.

// File: rtl/i2c_clk_pkg.sv
// Shared types for the I2C clock/timing generator.
package i2c_clk_pkg;

    // Phase of the generator; each running phase has its own length.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // bus free, both lines released
        ST_HOLD   = 3'd1,  // bus owned, SCL held low awaiting request
        ST_LOW    = 3'd2,  // SCL low phase of any operation
        ST_BIT_HI = 3'd3,  // SCL high phase of a data bit
        ST_STA_SU = 3'd4,  // SCL high, SDA high: START setup
        ST_STA_HD = 3'd5,  // SCL high, SDA low: START hold
        ST_STO_SU = 3'd6   // SCL high, SDA low: STOP setup
    } gen_state_e;

    // Kind of operation carried through the low phase.
    typedef enum logic [1:0] {
        OP_BIT   = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2
    } op_kind_e;

endpackage

// File: rtl/i2c_clk_cfg.sv
// Configuration latch and phase-length calculator.
// Captures divider and tuning fields when an operation is accepted and
// derives every phase length and strobe offset from the captured copy.
// Assumes load_i is only raised with both count fields nonzero.
module i2c_clk_cfg #(
    parameter int DIV_W = 16,
    parameter int SDA_W = 4,
    parameter int STA_W = 2,
    parameter int STO_W = 2,
    parameter int CNT_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 load_i,
    input  logic [2*DIV_W-1:0]   div_i,
    input  logic [SDA_W-1:0]     sda_cfg_i,
    input  logic [STA_W-1:0]     sta_cfg_i,
    input  logic [STO_W-1:0]     sto_cfg_i,
    output logic [CNT_W-1:0]     len_low_o,
    output logic [CNT_W-1:0]     len_high_o,
    output logic [CNT_W-1:0]     upd_at_o,
    output logic [CNT_W-1:0]     smp_at_o,
    output logic [CNT_W-1:0]     sta_su_len_o,
    output logic [CNT_W-1:0]     sta_hd_len_o,
    output logic [CNT_W-1:0]     sto_su_len_o
);

    localparam int CW    = DIV_W + 1;
    localparam int S_MAX = 7;

    logic [CW-1:0]    l_q, h_q;
    logic [2:0]       s_q, s_next;
    logic [STA_W:0]   u_q;
    logic [STO_W:0]   p_q;

    // Limit the update multiplier so the change stays inside the low phase.
    always_comb begin
        if (32'(sda_cfg_i) >= S_MAX - 1) s_next = 3'(S_MAX);
        else                             s_next = 3'(sda_cfg_i) + 3'd1;
    end

    // Capture effective multipliers at operation acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            l_q <= '0;
            h_q <= '0;
            s_q <= '0;
            u_q <= '0;
            p_q <= '0;
        end else if (load_i) begin
            l_q <= {1'b0, div_i[DIV_W-1:0]} + CW'(1);
            h_q <= {1'b0, div_i[2*DIV_W-1:DIV_W]} + CW'(1);
            s_q <= s_next;
            u_q <= {1'b0, sta_cfg_i} + (STA_W+1)'(1);
            p_q <= {1'b0, sto_cfg_i} + (STO_W+1)'(1);
        end
    end

    assign len_low_o    = CNT_W'(l_q) << 3;
    assign len_high_o   = CNT_W'(h_q) << 3;
    assign upd_at_o     = CNT_W'(l_q) * CNT_W'(s_q);
    assign smp_at_o     = CNT_W'(h_q) << 2;
    assign sta_su_len_o = ((CNT_W'(h_q) * CNT_W'(u_q)) << 3) + CNT_W'(1);
    assign sta_hd_len_o = ((CNT_W'(h_q) * (CNT_W'(u_q) + CNT_W'(1))) << 3) - CNT_W'(1);
    assign sto_su_len_o = ((CNT_W'(h_q) * CNT_W'(p_q)) << 3) + CNT_W'(1);

    // A load must never capture a zero count field.
    assert_load_valid_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (div_i[DIV_W-1:0] != '0 && div_i[2*DIV_W-1:DIV_W] != '0));

endmodule

// File: rtl/i2c_clk_cnt.sv
// Phase counter: counts input clocks inside the current phase and flags
// the final cycle. Assumes len_i is at least 1 whenever run_i is high.
module i2c_clk_cnt #(
    parameter int CNT_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Advance within a phase; zero on a new phase or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || restart_i || !run_i) cnt_q <= '0;
        else                                        cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o  = cnt_q;
    assign last_o = run_i && (cnt_q == len_i - CNT_W'(1));

    // The count never passes the length of the running phase.
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/i2c_clk_gen.sv
// I2C SCL and condition timing generator.
// Sequences START, STOP and single-bit operations. SCL and SDA levels,
// update/sample strobes and completion pulses all come from one phase
// state and one phase counter. Assumes requests are raised only when
// ready_o is high; others are ignored.
module i2c_clk_gen
    import i2c_clk_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SDA_W = 4,
    parameter int STA_W = 2,
    parameter int STO_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [2*DIV_W-1:0]  div_i,
    input  logic [SDA_W-1:0]    sda_cfg_i,
    input  logic [STA_W-1:0]    sta_cfg_i,
    input  logic [STO_W-1:0]    sto_cfg_i,
    input  logic                req_start_i,
    input  logic                req_stop_i,
    input  logic                req_bit_i,
    input  logic                bit_i,
    output logic                ready_o,
    output logic                scl_o,
    output logic                sda_o,
    output logic                upd_stb_o,
    output logic                smp_stb_o,
    output logic                sta_done_o,
    output logic                sto_done_o,
    output logic                bit_done_o
);

    localparam int MUL_W = ((STA_W > STO_W) ? STA_W : STO_W) + 1;
    localparam int CNT_W = DIV_W + 1 + MUL_W + 3;

    gen_state_e        state_q, state_n;
    op_kind_e          op_q, op_sel;
    logic              tgt_q, tgt_sel;
    logic              sda_q;
    logic              run, last, restart, div_ok, bus_owned;
    logic              acc_start, acc_stop, acc_bit, accept;
    logic [CNT_W-1:0]  cnt, cur_len;
    logic [CNT_W-1:0]  len_low, len_high, upd_at, smp_at;
    logic [CNT_W-1:0]  sta_su_len, sta_hd_len, sto_su_len;

    i2c_clk_cfg #(
        .DIV_W(DIV_W), .SDA_W(SDA_W), .STA_W(STA_W), .STO_W(STO_W), .CNT_W(CNT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (!en_i),
        .load_i       (accept),
        .div_i        (div_i),
        .sda_cfg_i    (sda_cfg_i),
        .sta_cfg_i    (sta_cfg_i),
        .sto_cfg_i    (sto_cfg_i),
        .len_low_o    (len_low),
        .len_high_o   (len_high),
        .upd_at_o     (upd_at),
        .smp_at_o     (smp_at),
        .sta_su_len_o (sta_su_len),
        .sta_hd_len_o (sta_hd_len),
        .sto_su_len_o (sto_su_len)
    );

    i2c_clk_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (!en_i),
        .run_i     (run),
        .restart_i (restart),
        .len_i     (cur_len),
        .cnt_o     (cnt),
        .last_o    (last)
    );

    // Which phases consume time, and how long each lasts.
    always_comb begin
        run = 1'b1;
        unique case (state_q)
            ST_LOW:    cur_len = len_low;
            ST_BIT_HI: cur_len = len_high;
            ST_STA_SU: cur_len = sta_su_len;
            ST_STA_HD: cur_len = sta_hd_len;
            ST_STO_SU: cur_len = sto_su_len;
            default: begin
                cur_len = len_low;
                run     = 1'b0;
            end
        endcase
    end

    // Request acceptance: START over STOP over bit; bus must be owned for STOP/bit.
    assign div_ok    = (div_i[DIV_W-1:0] != '0) && (div_i[2*DIV_W-1:DIV_W] != '0);
    assign bus_owned = (state_q != ST_IDLE);
    assign ready_o   = en_i && div_ok &&
                       ((state_q == ST_IDLE) || (state_q == ST_HOLD) ||
                        (last && ((state_q == ST_BIT_HI) || (state_q == ST_STA_HD))));
    assign acc_start = ready_o && req_start_i;
    assign acc_stop  = ready_o && !req_start_i && req_stop_i && bus_owned;
    assign acc_bit   = ready_o && !req_start_i && !req_stop_i && req_bit_i && bus_owned;
    assign accept    = acc_start || acc_stop || acc_bit;
    assign restart   = accept || last;

    // Operation kind and SDA target chosen by the accepted request.
    always_comb begin
        if (acc_start) begin
            op_sel  = OP_START;
            tgt_sel = 1'b1;
        end else if (acc_stop) begin
            op_sel  = OP_STOP;
            tgt_sel = 1'b0;
        end else begin
            op_sel  = OP_BIT;
            tgt_sel = bit_i;
        end
    end

    // Phase sequencing.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_start) state_n = ST_STA_SU;
            ST_HOLD:   if (accept)    state_n = ST_LOW;
            ST_LOW: begin
                if (last) begin
                    unique case (op_q)
                        OP_START: state_n = ST_STA_SU;
                        OP_STOP:  state_n = ST_STO_SU;
                        default:  state_n = ST_BIT_HI;
                    endcase
                end
            end
            ST_BIT_HI, ST_STA_HD: if (last) state_n = accept ? ST_LOW : ST_HOLD;
            ST_STA_SU: if (last) state_n = ST_STA_HD;
            ST_STO_SU: if (last) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Phase state register; disable returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) state_q <= ST_IDLE;
        else                 state_q <= state_n;
    end

    // Hold the operation kind and SDA target through the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            op_q  <= OP_BIT;
            tgt_q <= 1'b1;
        end else if (accept) begin
            op_q  <= op_sel;
            tgt_q <= tgt_sel;
        end
    end

    // SDA level: update point in low phase, START fall, STOP rise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)                          sda_q <= 1'b1;
        else if (state_q == ST_LOW && cnt == upd_at)  sda_q <= tgt_q;
        else if (state_q == ST_STA_SU && last)        sda_q <= 1'b0;
        else if (state_q == ST_STO_SU && last)        sda_q <= 1'b1;
    end

    assign sda_o      = sda_q;
    assign scl_o      = (state_q != ST_LOW) && (state_q != ST_HOLD);
    assign upd_stb_o  = (state_q == ST_LOW) && (cnt == upd_at);
    assign smp_stb_o  = (state_q == ST_BIT_HI) && (cnt == smp_at);
    assign sta_done_o = (state_q == ST_STA_HD) && last;
    assign sto_done_o = (state_q == ST_STO_SU) && last;
    assign bit_done_o = (state_q == ST_BIT_HI) && last;

    // Disable releases both lines on the next cycle.
    assert_release_on_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (scl_o && sda_o));

    // Update strobe only while the clock is low.
    assert_update_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |-> !scl_o);

    // Sample strobe only while the clock is high.
    assert_sample_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_o |-> scl_o);

    // SDA falls under a steady high clock only as a START.
    assert_start_only_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_o) && scl_o && $past(scl_o)) |-> (state_q == ST_STA_HD));

    // SDA rises under a steady high clock only at the end of a STOP.
    assert_stop_only_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_o) && scl_o && $past(scl_o) && $past(en_i)) |-> $past(sto_done_o));

    // Completion pulses are mutually exclusive.
    assert_done_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sta_done_o, sto_done_o, bit_done_o}));

endmodule

// File: tb/i2c_clk_gen_tb.sv
`timescale 1ns/1ps
module i2c_clk_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [15:0] lo, hi;
    logic [3:0]  sda_cfg;
    logic [1:0]  sta_cfg, sto_cfg;
    logic        req_start, req_stop, req_bit, bit_v;
    logic        ready, scl, sda, upd_stb, smp_stb, sta_done, sto_done, bit_done;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_clk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .div_i({hi, lo}),
        .sda_cfg_i(sda_cfg), .sta_cfg_i(sta_cfg), .sto_cfg_i(sto_cfg),
        .req_start_i(req_start), .req_stop_i(req_stop), .req_bit_i(req_bit), .bit_i(bit_v),
        .ready_o(ready), .scl_o(scl), .sda_o(sda), .upd_stb_o(upd_stb), .smp_stb_o(smp_stb),
        .sta_done_o(sta_done), .sto_done_o(sto_done), .bit_done_o(bit_done)
    );

    // Vectors: {low count, high count, sda field, start field, stop field}
    localparam logic [39:0] VEC [4] = '{
        {16'd1, 16'd2, 4'd3, 2'd0, 2'd0},
        {16'd3, 16'd1, 4'd0, 2'd3, 2'd2},
        {16'd2, 16'd2, 4'd9, 2'd1, 2'd3},
        {16'd5, 16'd4, 4'd6, 2'd2, 2'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // kind: 0 start, 1 stop, 2 bit. Returns the acceptance edge number.
    task automatic issue(input int kind, input logic b, output int t_acc);
        while (!ready) @(negedge clk);
        req_start = (kind == 0);
        req_stop  = (kind == 1);
        req_bit   = (kind == 2);
        bit_v     = b;
        t_acc     = cyc + 1;
        @(negedge clk);
        req_start = 1'b0;
        req_stop  = 1'b0;
        req_bit   = 1'b0;
    endtask

    task automatic wait_scl(input logic v, output int t);
        while (scl !== v) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_sda(input logic v, output int t);
        while (sda !== v) @(negedge clk);
        t = cyc;
    endtask

    task automatic run_vec(input logic [39:0] v);
        int l, h, s, u, p, ta, t1, t2, tr, ts, tf;
        lo = v[39:24]; hi = v[23:8]; sda_cfg = v[7:4]; sta_cfg = v[3:2]; sto_cfg = v[1:0];
        l = int'(lo) + 1; h = int'(hi) + 1;
        s = (int'(sda_cfg) >= 6) ? 7 : int'(sda_cfg) + 1;
        u = int'(sta_cfg) + 1; p = int'(sto_cfg) + 1;
        issue(0, 1'b0, ta);
        wait_sda(1'b0, t1);
        chk_eq("R5 start setup", t1 - ta, 8*h*u + 1);
        wait_scl(1'b0, t2);
        chk_eq("R5 start hold", t2 - t1, 8*h*(u+1) - 1);
        issue(2, 1'b1, ta);
        wait_sda(1'b1, t1);
        chk_eq("R3 sda update rise", t1 - ta, l*s + 1);
        wait_scl(1'b1, tr);
        chk_eq("R2 low phase", tr - ta, 8*l);
        while (!smp_stb) @(negedge clk);
        ts = cyc;
        chk_eq("R4 sample point", ts - tr, 4*h);
        wait_scl(1'b0, tf);
        chk_eq("R2 high phase", tf - tr, 8*h);
        issue(2, 1'b0, ta);
        wait_sda(1'b0, t1);
        chk_eq("R3 sda update fall", t1 - ta, l*s + 1);
        wait_scl(1'b1, tr);
        wait_scl(1'b0, tf);
        issue(1, 1'b0, ta);
        wait_scl(1'b1, tr);
        wait_sda(1'b1, t1);
        chk_eq("R7 stop setup", t1 - tr, 8*h*p + 1);
        @(negedge clk);
        check(scl && sda && ready, "R1 idle after stop", {scl, sda, ready}, 7);
    endtask

    initial begin
        int ta, t1, tr1, tr2, tf, bad;
        rst_n = 1'b0; en = 1'b1; lo = 16'd1; hi = 16'd2;
        sda_cfg = 4'd1; sta_cfg = 2'd0; sto_cfg = 2'd0;
        req_start = 1'b0; req_stop = 1'b0; req_bit = 1'b0; bit_v = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl && sda && ready, "R1 reset state", {scl, sda, ready}, 7);

        for (int i = 0; i < 4; i++) run_vec(VEC[i]);

        // R11: bit and stop requests on idle bus are ignored
        lo = 16'd1; hi = 16'd2; sda_cfg = 4'd1; sta_cfg = 2'd0; sto_cfg = 2'd0;
        issue(2, 1'b0, ta);
        issue(1, 1'b0, ta);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            if (!scl || !sda) bad++;
            @(negedge clk);
        end
        chk_eq("R11 idle ignores bit/stop", bad, 0);

        // R10: zero count fields block everything
        for (int z = 0; z < 2; z++) begin
            lo = (z == 0) ? 16'd0 : 16'd3;
            hi = (z == 0) ? 16'd3 : 16'd0;
            req_start = 1'b1;
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!scl || !sda || ready) bad++;
            end
            req_start = 1'b0;
            chk_eq("R10 zero count ignored", bad, 0);
        end

        // R8, R9, R6: back-to-back bits, config change mid-bit, repeated START
        lo = 16'd1; hi = 16'd2; sda_cfg = 4'd1; sta_cfg = 2'd0; sto_cfg = 2'd0;
        issue(0, 1'b0, ta);
        wait_scl(1'b0, tf);
        issue(2, 1'b1, ta);
        wait_scl(1'b1, tr1);
        issue(2, 1'b0, ta);
        hi = 16'd5;
        wait_scl(1'b1, tr2);
        chk_eq("R8 back-to-back period", tr2 - tr1, 8*(2+3));
        wait_scl(1'b0, tf);
        chk_eq("R9 old high count kept", tf - tr2, 8*3);
        issue(2, 1'b0, ta);
        wait_scl(1'b1, tr1);
        wait_scl(1'b0, tf);
        chk_eq("R9 new high count used", tf - tr1, 8*6);
        issue(0, 1'b0, ta);
        wait_scl(1'b1, tr1);
        check(sda == 1'b1, "R6 sda released before restart", int'(sda), 1);
        wait_sda(1'b0, t1);
        chk_eq("R6 repeated start setup", t1 - tr1, 8*6*1 + 1);
        wait_scl(1'b0, tf);
        issue(1, 1'b0, ta);
        wait_sda(1'b1, t1);

        // R12: disable mid-operation releases the bus
        hi = 16'd2;
        issue(0, 1'b0, ta);
        wait_sda(1'b0, t1);
        en = 1'b0;
        @(negedge clk);
        check(scl && sda && !ready, "R12 disable release", {scl, sda, ready}, 6);
        en = 1'b1;
        @(negedge clk);
        check(scl && sda && ready, "R1 idle after re-enable", {scl, sda, ready}, 7);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule